// File: doc/BRIEF.md
# Prefetch Burst Data Serializer

This block is a gearbox between a wide memory-core data port and a narrow double-data-rate pin port. It uses a four-beat prefetch. On the read side, one 128-bit core word is captured in a single clock. It then leaves on two 32-bit lanes over the next two clocks. The rise lane models the beat sent on the rising clock edge and the fall lane models the beat sent on the falling edge. Per-byte strobe-enable bits are raised in exactly the clocks that carry data, so the strobes stay edge-aligned with the beats.

On the write side, the block gathers two clocks of rise/fall beat pairs, each with a per-byte mask. From these it builds one 128-bit core word, a 16-bit byte-enable and a single-clock write-valid pulse. Masked bytes are cleared in the assembled word.

A burst is 4 or 8 beats long. An 8-beat read burst is built from two core words loaded back to back. An 8-beat write burst produces two core words.

Top module: `prefetch_gearbox`

## Requirements
- R1: After reset, pinRdValid, rdLast, coreWrValid, coreWrByteEn and every pinRdStrobe bit are 0, and pinRise and pinFall are 0.
- R2: A rdLoad taken at a clock edge puts the word on the pins for the next two clocks. In the first clock, pinRise = word[31:0] and pinFall = word[63:32]. In the second clock, pinRise = word[95:64] and pinFall = word[127:96].
- R3: pinRdValid and all four pinRdStrobe bits are 1 exactly in the clocks that carry read beats. In every other clock they are 0, and pinRise and pinFall are 0.
- R4: With rdLen8 = 0 on the load, rdLast is 1 in the second clock of the word and in no other clock.
- R5: With rdLen8 = 1 on the first load, a second rdLoad must be given in the second clock of the first word. The pins then carry data for four clocks in a row, and rdLast is 1 only in the fourth.
- R6: A rdLoad in the first clock of a word already on the pins is ignored. The current word finishes unchanged, and no further data follows.
- R7: Two wrBeatValid clocks deliver beats 0 (rise) and 1 (fall), then beats 2 (rise) and 3 (fall). The core word is {beat3, beat2, beat1, beat0}. coreWrValid is 1 for exactly the one clock after the edge that takes the second pair.
- R8: Clocks with wrBeatValid = 0 between the two pairs of a word are waited out. No coreWrValid pulse appears until the second pair is taken.
- R9: A mask bit of 1 marks its byte as masked. coreWrByteEn is the inverted mask in beat order: bits 3:0 come from beat 0 and bits 15:12 from beat 3. Every masked byte of coreWrData reads 0.
- R10: An 8-beat write, given as four consecutive wrBeatValid clocks, produces two coreWrValid pulses two clocks apart, carrying the first and second words in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdLoad | input | 1 | Core read word present |
| rdLen8 | input | 1 | Burst of 8 when set on a burst's first load |
| rdWord | input | 128 | Core read word |
| pinRise | output | 32 | Read beat for the rising edge |
| pinFall | output | 32 | Read beat for the falling edge |
| pinRdValid | output | 1 | Read beats present on the pins |
| pinRdStrobe | output | 4 | Per-byte read strobe enable |
| rdLast | output | 1 | Final clock of a read burst |
| wrBeatValid | input | 1 | Write beat pair present |
| wrRise | input | 32 | Write beat from the rising edge |
| wrFall | input | 32 | Write beat from the falling edge |
| wrRiseMask | input | 4 | Byte mask of the rise beat, 1 = masked |
| wrFallMask | input | 4 | Byte mask of the fall beat, 1 = masked |
| coreWrValid | output | 1 | One-clock pulse for an assembled core word |
| coreWrData | output | 128 | Assembled core write word |
| coreWrByteEn | output | 16 | Core byte enables, 1 = write |

## Verification
The assertions check several rules on every clock:
- a write pulse never lasts two clocks;
- a read word always spans two clocks and only begins after a load;
- the pins are quiet and the strobes are off when no read is in flight;
- rdLast only occurs with valid data;
- a disabled byte of an assembled write word is always zero.

Only the bench scenarios can show that each beat comes from the right slice of the right word. They also show that an 8-beat read flows for four unbroken clocks, that a load in the first clock of a word is dropped, and that the byte enables follow beat order.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  // Beats per core access and the clocks they take on a two-edge pin port.
  localparam int PREFETCH = 4;
  localparam int PHASES   = PREFETCH / 2;
  localparam int PH_W     = (PHASES > 1) ? $clog2(PHASES) : 1;

  // Control to datapath strobes.
  typedef struct packed {
    logic            rdCapture;
    logic            rdDrive;
    logic [PH_W-1:0] rdSel;
    logic            wrShift;
    logic            wrCommit;
  } gbxStrobe_t;
endpackage

// File: rtl/gbx_ctrl.sv
module gbx_ctrl
  import gbx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdLoad,
  input  logic       rdLen8,
  input  logic       wrBeatValid,
  output logic       rdLast,
  output gbxStrobe_t strb
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  logic            rdActive;
  logic [PH_W-1:0] rdPhase;
  logic            rdExpectSecond;
  logic [PH_W-1:0] wrCount;
  logic            rdAccept;

  assign rdAccept = rdLoad && (!rdActive || (rdPhase == LAST_PH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdActive       <= 1'b0;
      rdPhase        <= '0;
      rdExpectSecond <= 1'b0;
    end else if (rdAccept) begin
      rdActive <= 1'b1;
      rdPhase  <= '0;
      if (rdExpectSecond) rdExpectSecond <= 1'b0;
      else                rdExpectSecond <= rdLen8;
    end else if (rdActive) begin
      if (rdPhase == LAST_PH) begin
        rdActive       <= 1'b0;
        rdExpectSecond <= 1'b0;
      end else begin
        rdPhase <= rdPhase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCount <= '0;
    end else if (wrBeatValid) begin
      if (wrCount == LAST_PH) wrCount <= '0;
      else                    wrCount <= wrCount + 1'b1;
    end
  end

  assign rdLast = rdActive && (rdPhase == LAST_PH) && !rdExpectSecond;

  always_comb begin
    strb.rdCapture = rdAccept;
    strb.rdDrive   = rdActive;
    strb.rdSel     = rdPhase;
    strb.wrShift   = wrBeatValid;
    strb.wrCommit  = wrBeatValid && (wrCount == LAST_PH);
  end
endmodule

// File: rtl/gbx_datapath.sv
module gbx_datapath
  import gbx_pkg::*;
#(
  parameter int BEAT_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  gbxStrobe_t                     strb,
  input  logic [BEAT_W*PREFETCH-1:0]     rdWord,
  input  logic [BEAT_W-1:0]              wrRise,
  input  logic [BEAT_W-1:0]              wrFall,
  input  logic [BEAT_W/8-1:0]            wrRiseMask,
  input  logic [BEAT_W/8-1:0]            wrFallMask,
  output logic [BEAT_W-1:0]              pinRise,
  output logic [BEAT_W-1:0]              pinFall,
  output logic                           pinRdValid,
  output logic [BEAT_W/8-1:0]            pinRdStrobe,
  output logic                           coreWrValid,
  output logic [BEAT_W*PREFETCH-1:0]     coreWrData,
  output logic [BEAT_W*PREFETCH/8-1:0]   coreWrByteEn
);
  localparam int WORD_W = BEAT_W * PREFETCH;
  localparam int LANES  = BEAT_W / 8;
  localparam int BE_W   = WORD_W / 8;
  localparam int PAIR_W = 2 * BEAT_W;
  localparam int PAIR_B = 2 * LANES;
  localparam int BUF_W  = WORD_W - PAIR_W;
  localparam int BUFB_W = BE_W - PAIR_B;

  // Read side: hold the word, pick a beat pair by phase.
  logic [WORD_W-1:0] rdHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdHold <= '0;
    else if (strb.rdCapture) rdHold <= rdWord;
  end

  always_comb begin
    if (strb.rdDrive) begin
      pinRise = rdHold[(2 * int'(strb.rdSel)) * BEAT_W +: BEAT_W];
      pinFall = rdHold[(2 * int'(strb.rdSel) + 1) * BEAT_W +: BEAT_W];
    end else begin
      pinRise = '0;
      pinFall = '0;
    end
  end

  assign pinRdValid  = strb.rdDrive;
  assign pinRdStrobe = {LANES{strb.rdDrive}};

  // Write side: shift beat pairs in from the top, oldest ends lowest.
  logic [BUF_W-1:0]  wrBuf;
  logic [BUFB_W-1:0] wrBufMask;
  logic [WORD_W-1:0] wrNext;
  logic [BE_W-1:0]   wrNextMask;
  logic [WORD_W-1:0] wrKeep;

  assign wrNext     = {wrFall, wrRise, wrBuf};
  assign wrNextMask = {wrFallMask, wrRiseMask, wrBufMask};

  for (genvar b = 0; b < BE_W; b++) begin : g_byteKeep
    assign wrKeep[b*8 +: 8] = {8{~wrNextMask[b]}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrBuf        <= '0;
      wrBufMask    <= '0;
      coreWrValid  <= 1'b0;
      coreWrData   <= '0;
      coreWrByteEn <= '0;
    end else begin
      coreWrValid <= strb.wrCommit;
      if (strb.wrShift) begin
        wrBuf     <= wrNext[WORD_W-1:PAIR_W];
        wrBufMask <= wrNextMask[BE_W-1:PAIR_B];
      end
      if (strb.wrCommit) begin
        coreWrData   <= wrNext & wrKeep;
        coreWrByteEn <= ~wrNextMask;
      end
    end
  end
endmodule

// File: rtl/prefetch_gearbox.sv
module prefetch_gearbox
  import gbx_pkg::*;
#(
  parameter int BEAT_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         rdLoad,
  input  logic                         rdLen8,
  input  logic [BEAT_W*PREFETCH-1:0]   rdWord,
  output logic [BEAT_W-1:0]            pinRise,
  output logic [BEAT_W-1:0]            pinFall,
  output logic                         pinRdValid,
  output logic [BEAT_W/8-1:0]          pinRdStrobe,
  output logic                         rdLast,
  input  logic                         wrBeatValid,
  input  logic [BEAT_W-1:0]            wrRise,
  input  logic [BEAT_W-1:0]            wrFall,
  input  logic [BEAT_W/8-1:0]          wrRiseMask,
  input  logic [BEAT_W/8-1:0]          wrFallMask,
  output logic                         coreWrValid,
  output logic [BEAT_W*PREFETCH-1:0]   coreWrData,
  output logic [BEAT_W*PREFETCH/8-1:0] coreWrByteEn
);
  gbxStrobe_t strb;

  gbx_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rdLoad      (rdLoad),
    .rdLen8      (rdLen8),
    .wrBeatValid (wrBeatValid),
    .rdLast      (rdLast),
    .strb        (strb)
  );

  gbx_datapath #(.BEAT_W(BEAT_W)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .rdWord       (rdWord),
    .wrRise       (wrRise),
    .wrFall       (wrFall),
    .wrRiseMask   (wrRiseMask),
    .wrFallMask   (wrFallMask),
    .pinRise      (pinRise),
    .pinFall      (pinFall),
    .pinRdValid   (pinRdValid),
    .pinRdStrobe  (pinRdStrobe),
    .coreWrValid  (coreWrValid),
    .coreWrData   (coreWrData),
    .coreWrByteEn (coreWrByteEn)
  );
endmodule

// File: rtl/gbx_checker.sv
module gbx_checker #(
  parameter int BEAT_W = 32,
  parameter int WORD_W = BEAT_W * 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                rdLoad,
  input logic [BEAT_W-1:0]   pinRise,
  input logic [BEAT_W-1:0]   pinFall,
  input logic                pinRdValid,
  input logic [BEAT_W/8-1:0] pinRdStrobe,
  input logic                rdLast,
  input logic                coreWrValid,
  input logic [WORD_W-1:0]   coreWrData,
  input logic [WORD_W/8-1:0] coreWrByteEn
);
  // R7: write-valid is a single-clock pulse
  p_wr_pulse_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    coreWrValid |=> !coreWrValid);

  // R2: a read word begins only after a load
  p_read_after_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinRdValid) |-> $past(rdLoad));

  // R2: a read word occupies two clocks
  p_read_two_clocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinRdValid) |=> pinRdValid);

  // R3: idle pins are zero and strobes are off
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !pinRdValid |-> (pinRise == '0 && pinFall == '0 && pinRdStrobe == '0));

  // R4: burst end only with data
  p_last_with_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdLast |-> pinRdValid);

  // R9: disabled bytes of an assembled word read zero
  for (genvar b = 0; b < WORD_W/8; b++) begin : g_maskChk
    p_masked_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
      (coreWrValid && !coreWrByteEn[b]) |-> (coreWrData[b*8 +: 8] == 8'h00));
  end
endmodule

bind prefetch_gearbox gbx_checker #(.BEAT_W(BEAT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .rdLoad       (rdLoad),
  .pinRise      (pinRise),
  .pinFall      (pinFall),
  .pinRdValid   (pinRdValid),
  .pinRdStrobe  (pinRdStrobe),
  .rdLast       (rdLast),
  .coreWrValid  (coreWrValid),
  .coreWrData   (coreWrData),
  .coreWrByteEn (coreWrByteEn)
);

// File: tb/tb_prefetch_gearbox.sv
module tb_prefetch_gearbox;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         rdLoad = 1'b0;
  logic         rdLen8 = 1'b0;
  logic [127:0] rdWord = '0;
  logic [31:0]  pinRise, pinFall;
  logic         pinRdValid;
  logic [3:0]   pinRdStrobe;
  logic         rdLast;
  logic         wrBeatValid = 1'b0;
  logic [31:0]  wrRise = '0, wrFall = '0;
  logic [3:0]   wrRiseMask = '0, wrFallMask = '0;
  logic         coreWrValid;
  logic [127:0] coreWrData;
  logic [15:0]  coreWrByteEn;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  prefetch_gearbox dut (.*);

  localparam logic [127:0] RD_VEC [4] = '{
    128'h33333333_22222222_11111111_00000000,
    128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF,
    128'hFFFFFFFF_00000000_FFFFFFFF_00000000,
    128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0};
  localparam logic [127:0] WR_VEC [4] = '{
    128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0,
    128'h76543210_FEDCBA98_13579BDF_02468ACE,
    128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
    128'h11223344_55667788_99AABBCC_DDEEFF00};
  localparam logic [15:0] WR_MSK [4] = '{16'h0000, 16'h8421, 16'hFFFF, 16'h0F0F};

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Sample at the negative edge the state left by the last rising edge.
  task automatic chkRd(input string req, input logic [31:0] r, input logic [31:0] f,
                       input logic v, input logic last);
    chk(req, {pinRise, pinFall, pinRdValid, pinRdStrobe, rdLast},
             {r, f, v, {4{v}}, last});
  endtask

  function automatic logic [127:0] keepBytes(input logic [127:0] d, input logic [15:0] m);
    logic [127:0] o;
    for (int b = 0; b < 16; b++) o[b*8 +: 8] = m[b] ? 8'h00 : d[b*8 +: 8];
    return o;
  endfunction

  task automatic drivePair(input logic [127:0] d, input logic [15:0] m, input int pair);
    wrBeatValid = 1'b1;
    wrRise      = d[pair*64 +: 32];
    wrFall      = d[pair*64 + 32 +: 32];
    wrRiseMask  = m[pair*8 +: 4];
    wrFallMask  = m[pair*8 + 4 +: 4];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chkRd("R1", 32'h0, 32'h0, 1'b0, 1'b0);
    chk("R1", {coreWrValid, coreWrByteEn}, 17'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 table of single-word reads
    for (int i = 0; i < 4; i++) begin
      rdLoad = 1'b1; rdLen8 = 1'b0; rdWord = RD_VEC[i];
      @(negedge clk);
      rdLoad = 1'b0;
      chkRd("R2", RD_VEC[i][31:0], RD_VEC[i][63:32], 1'b1, 1'b0);
      @(negedge clk);
      chkRd("R4", RD_VEC[i][95:64], RD_VEC[i][127:96], 1'b1, 1'b1);
      @(negedge clk);
      chkRd("R3", 32'h0, 32'h0, 1'b0, 1'b0);
    end

    // R7 R9 table of masked writes
    for (int i = 0; i < 4; i++) begin
      drivePair(WR_VEC[i], WR_MSK[i], 0);
      @(negedge clk);
      drivePair(WR_VEC[i], WR_MSK[i], 1);
      chk("R7", {127'h0, coreWrValid}, 128'h0);
      @(negedge clk);
      wrBeatValid = 1'b0;
      chk("R7", {127'h0, coreWrValid}, 128'h1);
      chk("R9", coreWrData, keepBytes(WR_VEC[i], WR_MSK[i]));
      chk("R9", {112'h0, coreWrByteEn}, {112'h0, ~WR_MSK[i]});
      @(negedge clk);
      chk("R7", {127'h0, coreWrValid}, 128'h0);
    end

    // R5 eight-beat read from two words
    rdLoad = 1'b1; rdLen8 = 1'b1; rdWord = RD_VEC[1];
    @(negedge clk);
    rdLoad = 1'b0; rdLen8 = 1'b0;
    chkRd("R5", RD_VEC[1][31:0], RD_VEC[1][63:32], 1'b1, 1'b0);
    @(negedge clk);
    chkRd("R5", RD_VEC[1][95:64], RD_VEC[1][127:96], 1'b1, 1'b0);
    rdLoad = 1'b1; rdWord = RD_VEC[3];
    @(negedge clk);
    rdLoad = 1'b0;
    chkRd("R5", RD_VEC[3][31:0], RD_VEC[3][63:32], 1'b1, 1'b0);
    @(negedge clk);
    chkRd("R5", RD_VEC[3][95:64], RD_VEC[3][127:96], 1'b1, 1'b1);
    @(negedge clk);
    chkRd("R5", 32'h0, 32'h0, 1'b0, 1'b0);

    // R6 load in the first clock of a word is dropped
    rdLoad = 1'b1; rdWord = RD_VEC[0];
    @(negedge clk);
    rdWord = RD_VEC[2];
    chkRd("R6", RD_VEC[0][31:0], RD_VEC[0][63:32], 1'b1, 1'b0);
    @(negedge clk);
    rdLoad = 1'b0;
    chkRd("R6", RD_VEC[0][95:64], RD_VEC[0][127:96], 1'b1, 1'b1);
    @(negedge clk);
    chkRd("R6", 32'h0, 32'h0, 1'b0, 1'b0);

    // R8 gap between pairs is waited out
    drivePair(WR_VEC[1], 16'h0000, 0);
    @(negedge clk);
    wrBeatValid = 1'b0;
    @(negedge clk);
    chk("R8", {127'h0, coreWrValid}, 128'h0);
    @(negedge clk);
    chk("R8", {127'h0, coreWrValid}, 128'h0);
    drivePair(WR_VEC[1], 16'h0000, 1);
    @(negedge clk);
    wrBeatValid = 1'b0;
    chk("R8", {127'h0, coreWrValid}, 128'h1);
    chk("R8", coreWrData, WR_VEC[1]);

    // R10 eight-beat write gives two words
    @(negedge clk);
    drivePair(WR_VEC[0], 16'h0000, 0);
    @(negedge clk);
    drivePair(WR_VEC[0], 16'h0000, 1);
    @(negedge clk);
    drivePair(WR_VEC[3], 16'h00F0, 0);
    chk("R10", {127'h0, coreWrValid}, 128'h1);
    chk("R10", coreWrData, WR_VEC[0]);
    @(negedge clk);
    drivePair(WR_VEC[3], 16'h00F0, 1);
    chk("R10", {127'h0, coreWrValid}, 128'h0);
    @(negedge clk);
    wrBeatValid = 1'b0;
    chk("R10", {127'h0, coreWrValid}, 128'h1);
    chk("R10", coreWrData, keepBytes(WR_VEC[3], 16'h00F0));
    chk("R10", {112'h0, coreWrByteEn}, {112'h0, 16'hFF0F});
    @(negedge clk);
    chk("R10", {127'h0, coreWrValid}, 128'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule